// File: doc/BRIEF.md
# USB Line State and Bus Event Detector

This block watches the two data lines of a low-speed or full-speed USB bus through a two-stage synchronizer. Each clock it names the line state as one of four symbols (SE0, J, K, SE1). The J/K naming depends on the speed the block currently believes is in effect. It also times every stretch of SE0. When a long stretch ends, it flags a bus reset. When a medium stretch ends while the bus runs at low speed, it flags a keep-alive.

The speed can be fixed to full or low by a configuration input. It can also be left to the block, which then infers the speed from the polarity of the idle line. It does this once after its own reset and again each time an SE0 of two or more samples ends. A request input moves the block into a low-speed-behind-a-hub mode. In that mode the line keeps full-speed polarity. This mode lasts until the next bus reset, or, in automatic mode, until the next speed inference.

The SE0 thresholds come from the sample-clock frequency parameter `SAMPLE_HZ`. KA_CYC = floor(SAMPLE_HZ × 1.2 µs) and RST_CYC = floor(SAMPLE_HZ × 2.5 µs). At the default of 48 MHz these are 57 and 120 samples. Bit recovery and packet decoding sit downstream and are not part of this block.

Top module: `usb_line_monitor`

## Requirements
- R1: Both lines low gives `sym_o` = 0 (SE0) and both lines high gives `sym_o` = 3 (SE1), whatever the speed.
- R2: With `speed_o` = 0 (full) or 2 (low via hub), D+ high and D- low gives `sym_o` = 1 (J) and the opposite state gives 2 (K). With `speed_o` = 1 (low) the J/K mapping is swapped.
- R3: The lines pass two synchronizer flops before classification, so `sym_o` shows a line change made before clock edge n from just after edge n+1.
- R4: In automatic mode (`cfg_mode_i` = 0 or 3), the first synchronized sample after block reset is taken as idle. D+ high selects full speed and D- high selects low speed. In fixed modes (1 = full, 2 = low) the reset speed is the configured one.
- R5: In automatic mode, when an SE0 of at least 2 samples ends, the block infers the speed again from the ending state. An SE0 of one sample changes nothing.
- R6: An SE0 of more than RST_CYC samples raises `bus_reset_o` for exactly one clock. This happens on the clock after the first non-SE0 synchronized sample, three edges after the line leaves SE0.
- R7: A bus reset sets the speed to the configured value in fixed modes, which also leaves hub mode. In automatic mode it takes the inferred speed, and SE1 gives full speed.
- R8: An SE0 of more than KA_CYC and at most RST_CYC samples raises `keep_alive_o` for one clock, with the same timing as R6. This happens only if the speed was 1 (low) while the SE0 lasted.
- R9: An SE0 of KA_CYC samples or fewer raises neither pulse.
- R10: A high `hub_ls_req_i` sampled at an edge sets `speed_o` = 2, unless an SE0 end or the initial inference is evaluated at the same edge.
- R11: In fixed modes the speed never changes because of the idle polarity.
- R12: The SE0 counter saturates. The two pulses are each one clock wide and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| cfg_mode_i | input | 2 | 0 automatic, 1 full speed, 2 low speed, 3 automatic |
| hub_ls_req_i | input | 1 | Enter low-speed-via-hub mode |
| sym_o | output | 2 | 0 SE0, 1 J, 2 K, 3 SE1 |
| speed_o | output | 2 | 0 full, 1 low, 2 low via hub |
| bus_reset_o | output | 1 | One-clock bus reset pulse |
| keep_alive_o | output | 1 | One-clock keep-alive pulse |

## Verification
SE0 stretches of 1, 2, 57, 58, 120, 121 and up to 200 samples separate the no-event, keep-alive and reset bands at both edges. The one-sample glitch separates a real speed inference from noise. Each stretch ends in either polarity under automatic, fixed-full and fixed-low configuration, with hub requests mixed in. This shows whether the inferred speed, the J/K naming and the keep-alive gating follow the speed that held during the SE0 rather than the one after it. Random stretch lengths and end states, from a fixed seed, are checked against a bench model of the speed.

// File: rtl/usb_lm_pkg.sv
// Shared encodings for the USB line monitor.
package usb_lm_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'd0,
        SYM_J   = 2'd1,
        SYM_K   = 2'd2,
        SYM_SE1 = 2'd3
    } line_sym_t;

    typedef enum logic [1:0] {
        SPD_FULL = 2'd0,
        SPD_LOW  = 2'd1,
        SPD_HUB  = 2'd2
    } speed_t;

    localparam logic [1:0] CFG_FULL = 2'd1;
    localparam logic [1:0] CFG_LOW  = 2'd2;

    // Any code other than fixed full or fixed low means automatic.
    function automatic logic cfg_is_auto(logic [1:0] cfg);
        return (cfg != CFG_FULL) && (cfg != CFG_LOW);
    endfunction

    // Speed named by an idle line; dflt when the line shows no J polarity.
    function automatic speed_t idle_speed(logic dp, logic dm, speed_t dflt);
        if (dp && !dm)      return SPD_FULL;
        else if (!dp && dm) return SPD_LOW;
        else                return dflt;
    endfunction

    // Speed that a fixed configuration imposes (full when automatic).
    function automatic speed_t cfg_speed(logic [1:0] cfg);
        return (cfg == CFG_LOW) ? SPD_LOW : SPD_FULL;
    endfunction

endpackage

// File: rtl/usb_lm_sync.sv
// Multi-stage synchronizer for the bus lines.
// Assumes: inputs are asynchronous to clk; STAGES >= 2.
// vld_o rises once every stage holds a real sample after reset.
module usb_lm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic             vld_o
);

    logic [WIDTH-1:0]  stg_q [STAGES];
    logic [STAGES-1:0] fill_q;

    // Shift the lines through the stages and track pipeline fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            fill_q <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            fill_q <= {fill_q[STAGES-2:0], 1'b1};
        end
    end

    assign q_o   = stg_q[STAGES-1];
    assign vld_o = fill_q[STAGES-1];

    // R3: once the pipeline is full it stays full until reset.
    assert_fill_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> vld_o);

endmodule

// File: rtl/usb_lm_classify.sv
// Names the synchronized line state as SE0, J, K or SE1.
// Assumes: speed is the currently effective speed; only low speed
// swaps J and K, hub mode keeps full-speed polarity.
module usb_lm_classify
    import usb_lm_pkg::*;
(
    input  logic      dp_i,
    input  logic      dm_i,
    input  speed_t    spd_i,
    output line_sym_t sym_o
);

    logic low_pol;

    // Pick the J/K naming from the polarity the speed implies.
    always_comb begin
        low_pol = (spd_i == SPD_LOW);
        unique case ({dp_i, dm_i})
            2'b00:   sym_o = SYM_SE0;
            2'b11:   sym_o = SYM_SE1;
            2'b10:   sym_o = low_pol ? SYM_K : SYM_J;
            default: sym_o = low_pol ? SYM_J : SYM_K;
        endcase
    end

endmodule

// File: rtl/usb_lm_se0_timer.sv
// Counts consecutive SE0 samples and flags which duration band an SE0
// fell in when it ends.
// Assumes: se0_i is meaningful only while vld_i is high.
module usb_lm_se0_timer #(
    parameter int KA_CYC  = 57,
    parameter int RST_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic se0_i,
    output logic end_o,
    output logic long_o,
    output logic rst_hit_o,
    output logic ka_hit_o
);

    localparam int CNT_MAX = RST_CYC + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt_q;

    // Count SE0 samples up to saturation, clear on any other state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (vld_i) begin
            if (se0_i) begin
                if (cnt_q != CW'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign end_o     = vld_i && !se0_i && (cnt_q != '0);
    assign long_o    = cnt_q >= CW'(2);
    assign rst_hit_o = cnt_q > CW'(RST_CYC);
    assign ka_hit_o  = (cnt_q > CW'(KA_CYC)) && !rst_hit_o;

    // R12: the counter never passes its saturation value.
    assert_cnt_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CNT_MAX));

    // R6: after an SE0 ends the count restarts from zero.
    assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> (cnt_q == '0));

endmodule

// File: rtl/usb_line_monitor.sv
// USB line state and bus event detector.
// Synchronizes D+/D-, names the line symbol, times SE0 stretches for
// bus reset and keep-alive, and keeps the effective speed (fixed,
// inferred from the idle line, or low speed via hub).
// Assumes: SAMPLE_HZ is the frequency of clk; reset is synchronous.
module usb_line_monitor
    import usb_lm_pkg::*;
#(
    parameter int SAMPLE_HZ   = 48_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_i,
    input  logic       dm_i,
    input  logic [1:0] cfg_mode_i,
    input  logic       hub_ls_req_i,
    output logic [1:0] sym_o,
    output logic [1:0] speed_o,
    output logic       bus_reset_o,
    output logic       keep_alive_o
);

    localparam int KA_CYC  = int'((64'(SAMPLE_HZ) * 64'd12) / 64'd10_000_000);
    localparam int RST_CYC = int'((64'(SAMPLE_HZ) * 64'd25) / 64'd10_000_000);

    logic [1:0] line_s;
    logic       line_vld;
    logic       se0_end, se0_long, rst_hit, ka_hit;
    logic       init_pend_q, init_eval;
    logic       bus_reset_q, keep_alive_q;
    speed_t     speed_q;
    line_sym_t  sym;

    usb_lm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dp_i, dm_i}),
        .q_o   (line_s),
        .vld_o (line_vld)
    );

    usb_lm_classify u_classify (
        .dp_i  (line_s[1]),
        .dm_i  (line_s[0]),
        .spd_i (speed_q),
        .sym_o (sym)
    );

    usb_lm_se0_timer #(.KA_CYC(KA_CYC), .RST_CYC(RST_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (line_vld),
        .se0_i     (line_s == 2'b00),
        .end_o     (se0_end),
        .long_o    (se0_long),
        .rst_hit_o (rst_hit),
        .ka_hit_o  (ka_hit)
    );

    assign init_eval = line_vld && init_pend_q;

    // Keep the effective speed and raise the one-clock event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q      <= cfg_speed(cfg_mode_i);
            init_pend_q  <= 1'b1;
            bus_reset_q  <= 1'b0;
            keep_alive_q <= 1'b0;
        end else begin
            bus_reset_q  <= 1'b0;
            keep_alive_q <= 1'b0;
            if (init_eval) begin
                init_pend_q <= 1'b0;
                if (cfg_is_auto(cfg_mode_i))
                    speed_q <= idle_speed(line_s[1], line_s[0], speed_q);
            end else if (se0_end) begin
                bus_reset_q  <= rst_hit;
                keep_alive_q <= ka_hit && (speed_q == SPD_LOW);
                if (se0_long) begin
                    if (rst_hit)
                        speed_q <= cfg_is_auto(cfg_mode_i)
                                   ? idle_speed(line_s[1], line_s[0], SPD_FULL)
                                   : cfg_speed(cfg_mode_i);
                    else if (cfg_is_auto(cfg_mode_i))
                        speed_q <= idle_speed(line_s[1], line_s[0], speed_q);
                end
            end else if (hub_ls_req_i) begin
                speed_q <= SPD_HUB;
            end
        end
    end

    assign sym_o        = sym;
    assign speed_o      = speed_q;
    assign bus_reset_o  = bus_reset_q;
    assign keep_alive_o = keep_alive_q;

    // R8: a keep-alive only follows an SE0 timed while at low speed.
    assert_ka_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive_o |-> ($past(speed_q) == SPD_LOW));

    // R7: a bus reset under fixed full configuration lands at full speed.
    assert_rst_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_o && ($past(cfg_mode_i) == CFG_FULL)) |-> (speed_q == SPD_FULL));

    // R10: an honoured hub request yields hub mode.
    assert_hub_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hub_ls_req_i) && !$past(se0_end) && !$past(init_eval))
        |-> (speed_q == SPD_HUB));

    // R12: pulses never coincide and last one clock.
    assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_reset_o && keep_alive_o));
    assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_o |=> !bus_reset_o);
    assert_ka_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive_o |=> !keep_alive_o);

endmodule

// File: tb/test_usb_line_monitor.sv
module test_usb_line_monitor;
    import usb_lm_pkg::*;

    localparam int HZ      = 48_000_000;
    localparam int KA_LIM  = int'((64'(HZ) * 64'd12) / 64'd10_000_000);
    localparam int RST_LIM = int'((64'(HZ) * 64'd25) / 64'd10_000_000);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b1, dm = 1'b0, hub = 1'b0;
    logic [1:0] cfg = 2'd0;
    logic [1:0] sym, spd;
    logic       brst, ka;
    logic [1:0] m_spd;
    int         checks = 0, errors = 0;

    always #2 clk = ~clk;

    usb_line_monitor #(.SAMPLE_HZ(HZ)) i_usb_line_monitor (
        .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .cfg_mode_i(cfg),
        .hub_ls_req_i(hub), .sym_o(sym), .speed_o(spd),
        .bus_reset_o(brst), .keep_alive_o(ka)
    );

    function automatic logic [1:0] f_sym(logic d, logic m, logic [1:0] s);
        if (!d && !m) return 2'd0;
        if (d && m)   return 2'd3;
        if (s == 2'd1) return d ? 2'd2 : 2'd1;
        return d ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [1:0] f_idle(logic d, logic m, logic [1:0] dflt);
        if (d && !m) return 2'd0;
        if (!d && m) return 2'd1;
        return dflt;
    endfunction

    function automatic logic f_auto(logic [1:0] c);
        return (c != 2'd1) && (c != 2'd2);
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_line(logic d, logic m);
        dp = d; dm = m;
    endtask

    task automatic do_reset(logic [1:0] c, logic d, logic m);
        rst_n = 1'b0; cfg = c; set_line(d, m);
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (4) tick();
        m_spd = f_auto(c) ? f_idle(d, m, 2'd0) : ((c == 2'd2) ? 2'd1 : 2'd0);
        chk("R4 speed after reset", spd, m_spd);
        chk("R4 no pulse after reset", brst | ka, 0);
    endtask

    task automatic hub_req(string req);
        hub = 1'b1; tick(); hub = 1'b0; tick();
        m_spd = 2'd2;
        chk(req, spd, m_spd);
    endtask

    task automatic se0_burst(int n, logic d, logic m, string req);
        int nr = 0, nk = 0, both = 0;
        logic er, ek;
        set_line(1'b0, 1'b0);
        repeat (n) tick();
        if (n >= 3) chk("R1 SE0 symbol", sym, 0);
        set_line(d, m);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (brst) nr++;
            if (ka) nk++;
            if (brst && ka) both++;
        end
        er = (n > RST_LIM);
        ek = (n > KA_LIM) && (n <= RST_LIM) && (m_spd == 2'd1);
        if (n >= 2) begin
            if (er)
                m_spd = f_auto(cfg) ? f_idle(d, m, 2'd0) : ((cfg == 2'd2) ? 2'd1 : 2'd0);
            else if (f_auto(cfg))
                m_spd = f_idle(d, m, m_spd);
        end
        chk({req, " R6 reset pulse count"}, nr, int'(er));
        chk({req, " R8 keep-alive pulse count"}, nk, int'(ek));
        chk({req, " R12 pulses together"}, both, 0);
        chk({req, " speed after SE0"}, spd, m_spd);
        chk({req, " R2 symbol after SE0"}, sym, f_sym(d, m, m_spd));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));
        m_spd = 2'd0;

        // Automatic, idle D+ high: full speed.
        do_reset(2'd0, 1'b1, 1'b0);
        chk("R2 full J", sym, 1);
        set_line(1'b0, 1'b1);
        tick();
        chk("R3 not yet visible", sym, 1);
        tick();
        chk("R3 visible after two flops, R2 full K", sym, 2);
        set_line(1'b1, 1'b1);
        repeat (2) tick();
        chk("R1 SE1 symbol", sym, 3);
        set_line(1'b1, 1'b0);
        repeat (3) tick();
        chk("R1 SE1 left speed alone", spd, 0);

        // R5: one-sample SE0 changes nothing, two samples re-infer.
        se0_burst(1, 1'b0, 1'b1, "R5 glitch");
        se0_burst(2, 1'b0, 1'b1, "R5 two samples");

        // Automatic, idle D- high: low speed, band edges.
        do_reset(2'd3, 1'b0, 1'b1);
        chk("R2 low J", sym, 1);
        se0_burst(KA_LIM, 1'b0, 1'b1, "R9 at KA limit");
        se0_burst(KA_LIM + 1, 1'b0, 1'b1, "R8 just over KA limit");
        se0_burst(RST_LIM, 1'b0, 1'b1, "R8 at reset limit");
        se0_burst(RST_LIM + 1, 1'b0, 1'b1, "R6 just over reset limit");
        hub_req("R10 hub request in auto");
        chk("R2 hub polarity J", sym, f_sym(1'b0, 1'b1, 2'd2));
        se0_burst(80, 1'b1, 1'b0, "R8 no keep-alive in hub mode");

        // Fixed full speed.
        do_reset(2'd1, 1'b0, 1'b1);
        se0_burst(10, 1'b0, 1'b1, "R11 fixed full ignores polarity");
        hub_req("R10 hub request fixed full");
        se0_burst(30, 1'b1, 1'b0, "R10 hub held");
        se0_burst(130, 1'b1, 1'b0, "R7 reset to full");

        // Fixed low speed.
        do_reset(2'd2, 1'b1, 1'b0);
        se0_burst(100, 1'b0, 1'b1, "R8 keep-alive fixed low");
        se0_burst(40, 1'b1, 1'b0, "R11 fixed low ignores polarity");
        hub_req("R10 hub request fixed low");
        se0_burst(200, 1'b1, 1'b0, "R7 reset to low");

        // Random SE0 stretches and end states.
        for (int blk = 0; blk < 6; blk++) begin
            logic [1:0] c;
            logic       j;
            c = 2'($urandom % 4);
            j = 1'($urandom % 2);
            do_reset(c, j, !j);
            for (int it = 0; it < 10; it++) begin
                int  n;
                logic e;
                n = 1 + int'($urandom % 200);
                e = 1'($urandom % 2);
                if ($urandom % 6 == 0) hub_req("R10 random hub request");
                se0_burst(n, e, !e, "random R12");
            end
        end

        finish_run();
    end

endmodule